// File: doc/BRIEF.md
# Shared-Bus Debug Access Master

This block carries out single Wishbone classic read and write cycles for a debug command interpreter that sits in front of it. A command names a direction, a start address, a write value and a word count. The block asks a primary bus master for the bus and waits for the grant. It then runs one bus cycle per word on consecutive addresses. When the transfer ends it reports one status: ok, bus error or timeout.

Each cycle stays open for as many clocks as the slave needs. A watchdog counter limits that wait to `TIMEOUT` clocks. If the slave tie its acknowledge high, every word completes on its first bus clock. Where no other master exists, the grant input is tied high and the block becomes the only master on the bus. For a multi-word write, the same write value goes to every address in the range.

Top module: `wb_debug_master`

## Requirements
- R1: While `rstN` is low, and in the first clock after it rises, `busReq`, `wbCyc`, `wbStb`, `cmdBusy`, `cmdDone` and `wordValid` are low, `wbAdr`, `rdData` and `cmdStatus` are zero.
- R2: A `cmdStart` seen at a clock edge while idle latches the command. `busReq` and `cmdBusy` are high from the next clock and stay high until the transfer has ended.
- R3: A bus cycle starts in the clock after an edge at which `busReq` and `busGnt` were both high. `wbCyc` and `wbStb` rise together. `wbWe` equals the latched direction and `wbDatO` equals the latched write value.
- R4: A cycle holds `wbCyc`, `wbStb` and `wbAdr` steady until an edge where `wbAck` or `wbErr` is high. Both strobes are low in the clock after that edge. With `wbAck` tied high, each word takes exactly one bus clock.
- R5: If neither `wbAck` nor `wbErr` arrives during `TIMEOUT` consecutive bus clocks, the block drops the cycle after the last of them. The transfer then ends with status 2 (timeout).
- R6: `wbErr` during a bus clock ends the transfer with status 1 (bus error), even when `wbAck` is high in the same clock. Any remaining words are abandoned and `busReq` falls in the next clock.
- R7: On each acknowledged word, `wordValid` pulses for one clock. For reads, `rdData` takes the value of `wbDatI` at the acknowledging edge and holds it until the next acknowledged read.
- R8: A transfer covers `cmdCount`+1 words at addresses start, start+1, …, wrapping modulo 2^`ADDR_W`. One clock with `wbCyc` low and `busReq` still high separates the words, and grant is checked again before each word. `busReq` falls in the clock after the last word's acknowledge.
- R9: `cmdDone` pulses for one clock when a transfer ends, the same clock in which `busReq` falls. `cmdStatus` then shows 0 (ok), 1 (error) or 2 (timeout) and holds that value until the next transfer ends.
- R10: A `cmdStart` while `cmdBusy` is high is ignored. The running transfer keeps its addresses, direction and word count.
- R11: The watchdog restarts for every word, so each word of a transfer gets the full `TIMEOUT` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Single-clock command request |
| cmdWrite | input | 1 | 1 = write transfer, 0 = read transfer |
| cmdAddr | input | ADDR_W | First word address |
| cmdData | input | DATA_W | Value written to every word of a write transfer |
| cmdCount | input | CNT_W | Number of words minus one |
| cmdBusy | output | 1 | Transfer in progress |
| cmdDone | output | 1 | One-clock pulse at the end of a transfer |
| cmdStatus | output | 2 | Final status: 0 ok, 1 bus error, 2 timeout |
| wordValid | output | 1 | One-clock pulse per acknowledged word |
| rdData | output | DATA_W | Last read word |
| busReq | output | 1 | Bus request to the primary master |
| busGnt | input | 1 | Bus grant from the primary master (tie high when sole master) |
| wbCyc | output | 1 | Bus cycle valid |
| wbStb | output | 1 | Bus strobe |
| wbWe | output | 1 | Bus write enable |
| wbAdr | output | ADDR_W | Bus address |
| wbDatO | output | DATA_W | Bus write data |
| wbDatI | input | DATA_W | Bus read data |
| wbAck | input | 1 | Slave acknowledge |
| wbErr | input | 1 | Slave error |

## Verification
The assertions rely on the primary master keeping `busGnt` high for as long as a cycle is open. They also assume that `wbAck` and `wbErr` are only relevant while `wbCyc` is high. The bench's grant model therefore starts counting only once `busReq` rises, and holds the grant until `busReq` falls. The bench's slave model asserts its acknowledge and error only when `wbCyc` is high. The acknowledge and error delays are measured from the first clock of each cycle. Those delays are chosen to cover the boundaries: zero, exactly the last watchdog clock, never, and error coinciding with acknowledge.

// File: rtl/wbdm_pkg.sv
package wbdm_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BUSERR  = 2'd1,
    ST_TIMEOUT = 2'd2
  } status_e;

  typedef struct packed {
    logic load;     // latch command fields
    logic advance;  // step to next address
    logic capture;  // word acknowledged
  } dpCtl_t;

endpackage

// File: rtl/wbdm_datapath.sv
module wbdm_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wbdm_pkg::dpCtl_t      ctl,
  input  logic                  cmdWrite,
  input  logic [ADDR_W-1:0]     cmdAddr,
  input  logic [DATA_W-1:0]     cmdData,
  input  logic [DATA_W-1:0]     wbDatI,
  output logic [ADDR_W-1:0]     wbAdr,
  output logic [DATA_W-1:0]     wbDatO,
  output logic                  wbWe,
  output logic [DATA_W-1:0]     rdData
);

  localparam logic [ADDR_W-1:0] ADR_ONE = ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbAdr  <= '0;
      wbDatO <= '0;
      wbWe   <= 1'b0;
    end else if (ctl.load) begin
      wbAdr  <= cmdAddr;
      wbDatO <= cmdData;
      wbWe   <= cmdWrite;
    end else if (ctl.advance) begin
      wbAdr  <= wbAdr + ADR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.capture && !wbWe) begin
      rdData <= wbDatI;
    end
  end

endmodule

// File: rtl/wbdm_ctrl.sv
module wbdm_ctrl #(
  parameter int CNT_W   = 4,
  parameter int TIMEOUT = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdStart,
  input  logic [CNT_W-1:0]         cmdCount,
  input  logic                     busGnt,
  input  logic                     wbAck,
  input  logic                     wbErr,
  output wbdm_pkg::dpCtl_t         ctl,
  output logic                     busReq,
  output logic                     wbCyc,
  output logic                     cmdBusy,
  output logic                     cmdDone,
  output wbdm_pkg::status_e        cmdStatus,
  output logic                     wordValid
);
  import wbdm_pkg::*;

  localparam int WD_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT - 1);
  localparam logic [WD_W-1:0] WD_ONE  = WD_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_BUS} state_e;

  state_e           state;
  logic [CNT_W-1:0] wordsLeft;
  logic [WD_W-1:0]  wdCount;
  logic             wdExpired;
  logic             okEnd;

  assign wdExpired = (wdCount == WD_LAST);
  assign okEnd     = (state == S_BUS) && !wbErr && wbAck;

  assign busReq  = (state != S_IDLE);
  assign cmdBusy = (state != S_IDLE);
  assign wbCyc   = (state == S_BUS);

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == S_IDLE) && cmdStart;
    ctl.capture = okEnd;
    ctl.advance = okEnd && (wordsLeft != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      wordsLeft <= '0;
      wdCount   <= '0;
      cmdDone   <= 1'b0;
      cmdStatus <= ST_OK;
      wordValid <= 1'b0;
    end else begin
      cmdDone   <= 1'b0;
      wordValid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmdStart) begin
            wordsLeft <= cmdCount;
            state     <= S_REQ;
          end
        end
        S_REQ: begin
          wdCount <= '0;
          if (busGnt) state <= S_BUS;
        end
        S_BUS: begin
          wdCount <= wdCount + WD_ONE;
          if (wbErr) begin
            state     <= S_IDLE;
            cmdDone   <= 1'b1;
            cmdStatus <= ST_BUSERR;
          end else if (wbAck) begin
            wordValid <= 1'b1;
            if (wordsLeft == '0) begin
              state     <= S_IDLE;
              cmdDone   <= 1'b1;
              cmdStatus <= ST_OK;
            end else begin
              wordsLeft <= wordsLeft - 1'b1;
              state     <= S_REQ;
            end
          end else if (wdExpired) begin
            state     <= S_IDLE;
            cmdDone   <= 1'b1;
            cmdStatus <= ST_TIMEOUT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: a cycle opens only after request and grant were both seen
  p_cyc_after_gnt_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbCyc) |-> ($past(busGnt) && $past(busReq)));

  // R4: an acknowledge without error closes the cycle and flags the word
  p_ack_closes_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbAck && !wbErr) |=> (!wbCyc && wordValid));

  // R5: the watchdog never runs past its limit inside a cycle
  p_wd_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    wbCyc |-> (wdCount < WD_W'(TIMEOUT)));

  // R5: a timeout report follows the final watchdog clock
  p_timeout_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && cmdStatus == ST_TIMEOUT) |-> ($past(wdCount) == WD_LAST && $past(wbCyc)));

  // R6: an error ends the whole transfer and drops the request
  p_err_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbErr) |=> (!wbCyc && !busReq && cmdDone && cmdStatus == ST_BUSERR));

  // R9: done is a single-clock pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);

endmodule

// File: rtl/wb_debug_master.sv
module wb_debug_master #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [CNT_W-1:0]  cmdCount,
  output logic              cmdBusy,
  output logic              cmdDone,
  output logic [1:0]        cmdStatus,
  output logic              wordValid,
  output logic [DATA_W-1:0] rdData,
  output logic              busReq,
  input  logic              busGnt,
  output logic              wbCyc,
  output logic              wbStb,
  output logic              wbWe,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [DATA_W-1:0] wbDatO,
  input  logic [DATA_W-1:0] wbDatI,
  input  logic              wbAck,
  input  logic              wbErr
);

  wbdm_pkg::dpCtl_t  ctl;
  wbdm_pkg::status_e statusQ;

  wbdm_ctrl #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdCount(cmdCount),
    .busGnt(busGnt), .wbAck(wbAck), .wbErr(wbErr), .ctl(ctl),
    .busReq(busReq), .wbCyc(wbCyc), .cmdBusy(cmdBusy), .cmdDone(cmdDone),
    .cmdStatus(statusQ), .wordValid(wordValid)
  );

  wbdm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .wbDatI(wbDatI),
    .wbAdr(wbAdr), .wbDatO(wbDatO), .wbWe(wbWe), .rdData(rdData)
  );

  assign cmdStatus = statusQ;
  assign wbStb     = wbCyc;

  // R4: the address stays put while a cycle is open
  p_adr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && $past(wbCyc)) |-> $stable(wbAdr));

endmodule

// File: tb/wb_debug_master_bench.sv
module wb_debug_master_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int TO = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, cmdWrite = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic [CW-1:0] cmdCount = '0;
  logic cmdBusy, cmdDone, wordValid, busReq, wbCyc, wbStb, wbWe;
  logic [1:0] cmdStatus;
  logic [DW-1:0] rdData, wbDatO, wbDatI;
  logic [AW-1:0] wbAdr;
  logic busGnt, wbAck, wbErr;

  // bench-side slave and arbiter settings
  logic gntTied = 1'b1, ackTied = 1'b0, errOn = 1'b0;
  int gntDelay = 0, ackDelay = 0, errDelay = 0;
  int cycCnt = 0, gCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  wb_debug_master #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .TIMEOUT(TO)) u_wb_debug_master (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdCount(cmdCount),
    .cmdBusy(cmdBusy), .cmdDone(cmdDone), .cmdStatus(cmdStatus),
    .wordValid(wordValid), .rdData(rdData), .busReq(busReq), .busGnt(busGnt),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr), .wbDatO(wbDatO),
    .wbDatI(wbDatI), .wbAck(wbAck), .wbErr(wbErr)
  );

  always @(posedge clk) begin
    cycCnt <= (!rstN || !wbCyc) ? 0 : cycCnt + 1;
    gCnt   <= (!rstN || !busReq) ? 0 : gCnt + 1;
  end
  assign busGnt = gntTied || (busReq && gCnt >= gntDelay);
  assign wbAck  = wbCyc && (ackTied || cycCnt == ackDelay);
  assign wbErr  = wbCyc && errOn && cycCnt == errDelay;
  assign wbDatI = (wbAdr ^ 16'h5A5A) + 16'h0101;

  // behavioural reference model
  int mPhase = 0, mLeft = 0, mWait = 0;
  logic [AW-1:0] mAdr = '0;
  logic [DW-1:0] mDat = '0, mRd = '0;
  logic mWe = 0, mDone = 0, mValid = 0;
  int mStat = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mWait = 0; mAdr = '0; mDat = '0; mRd = '0;
      mWe = 0; mDone = 0; mValid = 0; mStat = 0;
    end else begin
      mDone = 0; mValid = 0;
      if (mPhase == 0) begin
        if (cmdStart) begin
          mAdr = cmdAddr; mDat = cmdData; mWe = cmdWrite; mLeft = int'(cmdCount);
          mPhase = 1;
        end
      end else if (mPhase == 1) begin
        mWait = 0;
        if (busGnt) mPhase = 2;
      end else begin
        if (wbErr) begin
          mPhase = 0; mDone = 1; mStat = 1;
        end else if (wbAck) begin
          mValid = 1;
          if (!mWe) mRd = wbDatI;
          if (mLeft == 0) begin mPhase = 0; mDone = 1; mStat = 0; end
          else begin mLeft--; mAdr = mAdr + 1'b1; mPhase = 1; end
        end else if (mWait == TO - 1) begin
          mPhase = 0; mDone = 1; mStat = 2;
        end else begin
          mWait++;
        end
      end
    end
  end

  int nChecks = 0, nFails = 0, cycleNo = 0;
  int cycHigh = 0, doneCnt = 0, okWords = 0;

  task automatic chk(input string what, input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycleNo);
    end
  endtask

  always @(negedge clk) begin
    string t;
    cycleNo++;
    if (cycleNo > 150000) begin
      nFails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
    t = rstN ? "" : "R1";
    chk("busReq",    (t != "") ? t : "R8", busReq,    mPhase != 0);
    chk("cmdBusy",   (t != "") ? t : "R2", cmdBusy,   mPhase != 0);
    chk("wbCyc",     (t != "") ? t : "R4", wbCyc,     mPhase == 2);
    chk("wbStb",     (t != "") ? t : "R4", wbStb,     mPhase == 2);
    chk("wbAdr",     (t != "") ? t : "R8", wbAdr,     mAdr);
    chk("wbWe",      (t != "") ? t : "R3", wbWe,      mWe);
    chk("wbDatO",    (t != "") ? t : "R3", wbDatO,    mDat);
    chk("cmdDone",   (t != "") ? t : "R9", cmdDone,   mDone);
    chk("cmdStatus", (t != "") ? t : "R6", cmdStatus, mStat);
    chk("wordValid", (t != "") ? t : "R7", wordValid, mValid);
    chk("rdData",    (t != "") ? t : "R7", rdData,    mRd);
    if (wbCyc) cycHigh++;
    if (cmdDone) doneCnt++;
    if (wordValid) okWords++;
  end

  task automatic runCmd(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int cnt);
    @(negedge clk);
    cycHigh = 0; doneCnt = 0; okWords = 0;
    cmdWrite = we; cmdAddr = a; cmdData = d; cmdCount = CW'(cnt); cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    while (!cmdDone) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // single write, grant tied, immediate ack
    ackDelay = 0; runCmd(1'b1, 16'h0040, 16'hBEEF, 0);
    // single read, delayed grant and ack
    gntTied = 0; gntDelay = 2; ackDelay = 3; runCmd(1'b0, 16'h1234, 16'h0, 0);
    // multi-word read with delays
    gntDelay = 1; ackDelay = 1; runCmd(1'b0, 16'h0100, 16'h0, 3);
    chk("words acked", "R8", okWords, 4);
    // timeout on a single word
    ackDelay = 1000; runCmd(1'b0, 16'h0200, 16'h0, 2);
    chk("cycle length at timeout", "R5", cycHigh, TO);
    chk("status timeout", "R5", cmdStatus, 2);
    // ack on last watchdog clock, each word
    gntTied = 1; ackDelay = TO - 1; runCmd(1'b1, 16'h0300, 16'h1111, 2);
    chk("words acked at watchdog edge", "R11", okWords, 3);
    chk("status ok", "R9", cmdStatus, 0);
    // error aborts a multi-word transfer
    errOn = 1; errDelay = 1; ackDelay = 1000; runCmd(1'b0, 16'h0400, 16'h0, 3);
    chk("words before error", "R6", okWords, 0);
    // error and ack together
    errDelay = 0; ackDelay = 0; runCmd(1'b1, 16'h0500, 16'h2222, 1);
    chk("status err wins", "R6", cmdStatus, 1);
    errOn = 0;
    // ack tied high: one clock per word, address wrap
    ackTied = 1; runCmd(1'b0, 16'hFFFE, 16'h0, 3);
    chk("bus clocks with ack tied", "R4", cycHigh, 4);
    ackTied = 0;
    // start while busy is ignored
    ackDelay = 4;
    @(negedge clk);
    cycHigh = 0; doneCnt = 0; okWords = 0;
    cmdWrite = 1'b0; cmdAddr = 16'h0600; cmdCount = CW'(2); cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    repeat (3) @(negedge clk);
    cmdWrite = 1'b1; cmdAddr = 16'h0900; cmdCount = CW'(7); cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    while (!cmdDone) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("transfers during busy start", "R10", doneCnt, 1);
    chk("words of running transfer", "R10", okWords, 3);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule